// File: doc/BRIEF.md
# PTP Event Frame Classifier

This block sits beside the receive and transmit byte streams at the media-independent interface side of an Ethernet MAC. For every frame it checks whether the frame is a precision-time-protocol event message. It runs up to five field comparisons at byte offsets that software programs. Each comparison can be masked on its own. When every comparison that takes part passes, the block stores the time value it saw when the frame's first byte went by. It stores this value in a 64-bit snapshot for that direction and raises a flag.

Software sets the comparisons through a small word-addressed register port. It reads each snapshot as a low word and then a high word, and reading the high word frees the snapshot for the next event. On the transmit side a frame is a candidate only if its 16-bit length word has the timestamp-request bit set. The length word is presented with the first byte of the frame. The time base is an external 64-bit input.

Top module: `ptp_event_classifier`

## Requirements
- R1: After reset the register reads are: control (address 0) 0x00001F00, offsets (1) 0x4A24170C, value A (2) 0x11040800, value B (3) 0x0140013F, type mask (4) 0xFFFFFFFC and status (5) 0. Both flag outputs are low.
- R2: Control bit 0 is the global enable. Control bits 12:8 are the comparison mask, and a 0 bit means that comparison takes part. Control reads back as {19'b0, mask, 7'b0, enable}. Addresses 1 to 4 read back what was written.
- R3: Mask bit 8 is the EtherType comparison. The two bytes at offset offsets[7:0] (first byte most significant) must equal value A[15:0].
- R4: Mask bit 9 compares the upper nibble of the byte at offsets[7:0]+2 with value A[19:16]. Mask bit 10 compares the byte at offsets[15:8] with value A[31:24].
- R5: Mask bit 11 is the port comparison. The two bytes at offsets[23:16] (first byte most significant) must equal either value B[15:0] or value B[31:16].
- R6: Mask bit 12 is the message-type comparison on the byte at offsets[31:24]. It passes only when that byte is below 32 and type-mask bit [byte] is 0.
- R7: A frame whose last byte arrives before every byte of an enabled comparison has been seen does not match.
- R8: On a match the snapshot holds the value of time_now at the clock edge that accepted the frame's first byte. The flag is high from the second rising edge after the edge that accepted the last byte. Status bit 0 is the receive flag and bit 1 is the transmit flag. Snapshots are read at 6/7 (receive low/high) and 8/9 (transmit low/high).
- R9: While a flag is high, further matches leave its snapshot unchanged. Reading the low word does not clear the flag. A read of the high word clears it.
- R10: A transmit frame is captured only if bit 12 of tx_len_word, sampled with its first byte, is 1. The receive and transmit flags are independent.
- R11: With the global enable at 0, no frame sets a flag.
- R12: With mask bit 12 clear and the type mask all ones, no frame matches.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rx_sof | input | 1 | Receive byte is the first of a frame |
| rx_vld | input | 1 | Receive byte valid |
| rx_last | input | 1 | Receive byte is the last of a frame |
| rx_data | input | 8 | Receive byte |
| tx_sof | input | 1 | Transmit byte is the first of a frame |
| tx_vld | input | 1 | Transmit byte valid |
| tx_last | input | 1 | Transmit byte is the last of a frame |
| tx_data | input | 8 | Transmit byte |
| tx_len_word | input | 16 | Transmit length word; bit 12 requests a stamp |
| time_now | input | 64 | Current time value |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (side effects) |
| reg_addr | input | 4 | Register word address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational) |
| rx_stamp_valid | output | 1 | Receive snapshot held |
| tx_stamp_valid | output | 1 | Transmit snapshot held |

## Verification
The assertions check the following on every cycle. A held snapshot never changes and its flag never drops until a high-word read. Each high-word read clears its flag on the next edge. A flag rises only two edges after the last byte of a frame in its own direction. Only the bench scenarios can show the rest. That covers the match decision itself over sweeps of message-type bytes and type masks in both transport layouts, each field mismatch and mask override, the short-frame cutoff, and the transmit request bit. It also covers the captured time matching the first-byte edge.

// File: rtl/ptp_cls_pkg.sv
// Shared constants, register addresses and configuration type of the
// PTP event classifier. Assumes 32-bit register words.
package ptp_cls_pkg;
    localparam int REG_AW     = 4;
    localparam int REG_DW     = 32;
    localparam int NUM_FIELDS = 5;

    localparam logic [REG_AW-1:0] A_CTRL  = 4'd0;
    localparam logic [REG_AW-1:0] A_OFFS  = 4'd1;
    localparam logic [REG_AW-1:0] A_VALA  = 4'd2;
    localparam logic [REG_AW-1:0] A_VALB  = 4'd3;
    localparam logic [REG_AW-1:0] A_TMASK = 4'd4;
    localparam logic [REG_AW-1:0] A_STAT  = 4'd5;
    localparam logic [REG_AW-1:0] A_RXLO  = 4'd6;
    localparam logic [REG_AW-1:0] A_RXHI  = 4'd7;
    localparam logic [REG_AW-1:0] A_TXLO  = 4'd8;
    localparam logic [REG_AW-1:0] A_TXHI  = 4'd9;

    localparam logic [NUM_FIELDS-1:0] RST_MASK  = 5'b11111;
    localparam logic [REG_DW-1:0]     RST_OFFS  = 32'h4A24170C;
    localparam logic [REG_DW-1:0]     RST_VALA  = 32'h11040800;
    localparam logic [REG_DW-1:0]     RST_VALB  = 32'h0140013F;
    localparam logic [REG_DW-1:0]     RST_TMASK = 32'hFFFFFFFC;

    typedef struct packed {
        logic                  enable;
        logic [NUM_FIELDS-1:0] mask;
        logic [REG_DW-1:0]     offs;
        logic [REG_DW-1:0]     va;
        logic [REG_DW-1:0]     vb;
        logic [REG_DW-1:0]     tmask;
    } cls_cfg_t;
endpackage

// File: rtl/ptp_cls_regs.sv
// Configuration registers of the classifier and the high-word read clears.
// Assumes single-cycle write and read strobes from the register port.
module ptp_cls_regs
    import ptp_cls_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [REG_AW-1:0] reg_addr,
    input  logic [REG_DW-1:0] reg_wdata,
    output cls_cfg_t          cfg,
    output logic              rx_clr,
    output logic              tx_clr
);
    // Register writes, with reset to the documented defaults.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg.enable <= 1'b0;
            cfg.mask   <= RST_MASK;
            cfg.offs   <= RST_OFFS;
            cfg.va     <= RST_VALA;
            cfg.vb     <= RST_VALB;
            cfg.tmask  <= RST_TMASK;
        end else if (reg_wr) begin
            case (reg_addr)
                A_CTRL: begin
                    cfg.enable <= reg_wdata[0];
                    cfg.mask   <= reg_wdata[8 +: NUM_FIELDS];
                end
                A_OFFS:  cfg.offs  <= reg_wdata;
                A_VALA:  cfg.va    <= reg_wdata;
                A_VALB:  cfg.vb    <= reg_wdata;
                A_TMASK: cfg.tmask <= reg_wdata;
                default: ;
            endcase
        end
    end

    // A read of a high snapshot word frees that snapshot.
    assign rx_clr = reg_rd && (reg_addr == A_RXHI);
    assign tx_clr = reg_rd && (reg_addr == A_TXHI);
endmodule

// File: rtl/ptp_frame_match.sv
// Per-direction frame matcher. It counts bytes from the first byte of a
// frame (index 0) and evaluates the five field comparisons as their bytes
// go by. It decides on the last byte. The registered hit comes one cycle
// after that byte and carries the time seen at the frame's first byte.
// Assumes every frame starts with sof and ends with last, both with vld.
module ptp_frame_match
    import ptp_cls_pkg::*;
#(
    parameter int CNT_W = 12,
    parameter int TS_W  = 64
) (
    input  logic            clk,
    input  logic            rst_n,
    input  cls_cfg_t        cfg,
    input  logic            gate_in,
    input  logic            sof,
    input  logic            vld,
    input  logic            last,
    input  logic [7:0]      data,
    input  logic [TS_W-1:0] time_now,
    output logic            hit,
    output logic [TS_W-1:0] hit_ts
);
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    logic [CNT_W-1:0]      cnt_q, idx;
    logic [NUM_FIELDS-1:0] seen_q, bad_q, seen_n, bad_n, pass;
    logic                  alt_q, alt_n, gate_q, gate_c, start;
    logic [TS_W-1:0]       ts_q, ts_c;
    logic                  unused_va;

    assign unused_va = ^cfg.va[23:20];

    function automatic logic [CNT_W-1:0] at(input logic [7:0] o, input int unsigned add);
        return CNT_W'(o) + CNT_W'(add);
    endfunction

    // Per-byte comparison state for the frame in progress.
    always_comb begin
        start  = vld && sof;
        idx    = start ? '0 : cnt_q;
        gate_c = start ? gate_in : gate_q;
        ts_c   = start ? time_now : ts_q;
        seen_n = start ? '0 : seen_q;
        bad_n  = start ? '0 : bad_q;
        alt_n  = start ? 1'b0 : alt_q;
        if (vld) begin
            if (idx == at(cfg.offs[7:0], 0))
                bad_n[0] = bad_n[0] | (data != cfg.va[15:8]);
            if (idx == at(cfg.offs[7:0], 1)) begin
                bad_n[0]  = bad_n[0] | (data != cfg.va[7:0]);
                seen_n[0] = 1'b1;
            end
            if (idx == at(cfg.offs[7:0], 2)) begin
                bad_n[1]  = bad_n[1] | (data[7:4] != cfg.va[19:16]);
                seen_n[1] = 1'b1;
            end
            if (idx == at(cfg.offs[15:8], 0)) begin
                bad_n[2]  = bad_n[2] | (data != cfg.va[31:24]);
                seen_n[2] = 1'b1;
            end
            if (idx == at(cfg.offs[23:16], 0)) begin
                bad_n[3] = bad_n[3] | (data != cfg.vb[15:8]);
                alt_n    = alt_n | (data != cfg.vb[31:24]);
            end
            if (idx == at(cfg.offs[23:16], 1)) begin
                bad_n[3]  = bad_n[3] | (data != cfg.vb[7:0]);
                alt_n     = alt_n | (data != cfg.vb[23:16]);
                seen_n[3] = 1'b1;
            end
            if (idx == at(cfg.offs[31:24], 0)) begin
                bad_n[4]  = bad_n[4] | (data[7:5] != 3'd0) | cfg.tmask[data[4:0]];
                seen_n[4] = 1'b1;
            end
        end
    end

    // Per-field verdict: masked, or fully seen without mismatch.
    always_comb begin
        pass[0] = cfg.mask[0] | (seen_n[0] & ~bad_n[0]);
        pass[1] = cfg.mask[1] | (seen_n[1] & ~bad_n[1]);
        pass[2] = cfg.mask[2] | (seen_n[2] & ~bad_n[2]);
        pass[3] = cfg.mask[3] | (seen_n[3] & ~(bad_n[3] & alt_n));
        pass[4] = cfg.mask[4] | (seen_n[4] & ~bad_n[4]);
    end

    // Byte counter and comparison state registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            seen_q <= '0;
            bad_q  <= '0;
            alt_q  <= 1'b0;
            gate_q <= 1'b0;
            ts_q   <= '0;
        end else if (vld) begin
            cnt_q  <= (idx == CNT_MAX) ? idx : idx + 1'b1;
            seen_q <= seen_n;
            bad_q  <= bad_n;
            alt_q  <= alt_n;
            gate_q <= gate_c;
            ts_q   <= ts_c;
        end
    end

    // Registered end-of-frame decision.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hit    <= 1'b0;
            hit_ts <= '0;
        end else begin
            hit <= vld && last && cfg.enable && gate_c && (&pass);
            if (vld && last)
                hit_ts <= ts_c;
        end
    end
endmodule

// File: rtl/ptp_stamp_hold.sv
// Snapshot register with its valid flag. The first hit is held until a
// clear, and a clear wins over a hit in the same cycle.
module ptp_stamp_hold #(
    parameter int TS_W = 64
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            hit,
    input  logic [TS_W-1:0] hit_ts,
    input  logic            clr,
    output logic            valid,
    output logic [TS_W-1:0] snap
);
    // Capture into a free snapshot; release on clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid <= 1'b0;
            snap  <= '0;
        end else if (clr) begin
            valid <= 1'b0;
        end else if (hit && !valid) begin
            valid <= 1'b1;
            snap  <= hit_ts;
        end
    end
endmodule

// File: rtl/ptp_event_classifier.sv
// Top of the PTP event classifier: one matcher and one snapshot per
// direction, a shared configuration, and a combinational read mux.
// Assumes TS_W is twice the register word width.
module ptp_event_classifier
    import ptp_cls_pkg::*;
#(
    parameter int CNT_W = 12,
    parameter int TS_W  = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rx_sof,
    input  logic              rx_vld,
    input  logic              rx_last,
    input  logic [7:0]        rx_data,
    input  logic              tx_sof,
    input  logic              tx_vld,
    input  logic              tx_last,
    input  logic [7:0]        tx_data,
    input  logic [15:0]       tx_len_word,
    input  logic [TS_W-1:0]   time_now,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [REG_AW-1:0] reg_addr,
    input  logic [REG_DW-1:0] reg_wdata,
    output logic [REG_DW-1:0] reg_rdata,
    output logic              rx_stamp_valid,
    output logic              tx_stamp_valid
);
    localparam int NDIR = 2;
    localparam int HALF = TS_W / 2;

    cls_cfg_t          cfg;
    logic [NDIR-1:0]   sof_v, vld_v, last_v, gate_v, clr_v, hit_v, valid_v;
    logic [7:0]        data_v [NDIR];
    logic [TS_W-1:0]   hts_v  [NDIR];
    logic [TS_W-1:0]   snap_w [NDIR];
    logic              unused_len;

    assign unused_len = ^{tx_len_word[15:13], tx_len_word[11:0]};

    assign sof_v  = {tx_sof, rx_sof};
    assign vld_v  = {tx_vld, rx_vld};
    assign last_v = {tx_last, rx_last};
    assign gate_v = {tx_len_word[12], 1'b1};
    assign data_v[0] = rx_data;
    assign data_v[1] = tx_data;

    ptp_cls_regs u_regs (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .cfg(cfg),
        .rx_clr(clr_v[0]), .tx_clr(clr_v[1])
    );

    for (genvar d = 0; d < NDIR; d++) begin : g_dir
        ptp_frame_match #(.CNT_W(CNT_W), .TS_W(TS_W)) u_match (
            .clk(clk), .rst_n(rst_n), .cfg(cfg), .gate_in(gate_v[d]),
            .sof(sof_v[d]), .vld(vld_v[d]), .last(last_v[d]),
            .data(data_v[d]), .time_now(time_now),
            .hit(hit_v[d]), .hit_ts(hts_v[d])
        );
        ptp_stamp_hold #(.TS_W(TS_W)) u_hold (
            .clk(clk), .rst_n(rst_n), .hit(hit_v[d]), .hit_ts(hts_v[d]),
            .clr(clr_v[d]), .valid(valid_v[d]), .snap(snap_w[d])
        );
    end

    assign rx_stamp_valid = valid_v[0];
    assign tx_stamp_valid = valid_v[1];

    // Register read mux.
    always_comb begin
        case (reg_addr)
            A_CTRL:  reg_rdata = {19'd0, cfg.mask, 7'd0, cfg.enable};
            A_OFFS:  reg_rdata = cfg.offs;
            A_VALA:  reg_rdata = cfg.va;
            A_VALB:  reg_rdata = cfg.vb;
            A_TMASK: reg_rdata = cfg.tmask;
            A_STAT:  reg_rdata = {30'd0, valid_v};
            A_RXLO:  reg_rdata = REG_DW'(snap_w[0][HALF-1:0]);
            A_RXHI:  reg_rdata = REG_DW'(snap_w[0][TS_W-1:HALF]);
            A_TXLO:  reg_rdata = REG_DW'(snap_w[1][HALF-1:0]);
            A_TXHI:  reg_rdata = REG_DW'(snap_w[1][TS_W-1:HALF]);
            default: reg_rdata = '0;
        endcase
    end
endmodule

// File: rtl/ptp_event_classifier_chk.sv
// Temporal checks on the classifier's snapshot flags, bound to the top.
module ptp_event_classifier_chk
    import ptp_cls_pkg::*;
#(
    parameter int TS_W = 64
) (
    input logic              clk,
    input logic              rst_n,
    input logic              rx_vld,
    input logic              rx_last,
    input logic              tx_vld,
    input logic              tx_last,
    input logic              reg_rd,
    input logic [REG_AW-1:0] reg_addr,
    input logic              rx_stamp_valid,
    input logic              tx_stamp_valid,
    input logic [TS_W-1:0]   rx_snap,
    input logic [TS_W-1:0]   tx_snap
);
    // R9: a held receive stamp stays until its high word is read.
    p_hold_rx_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_stamp_valid && !(reg_rd && reg_addr == A_RXHI)) |=> (rx_stamp_valid && $stable(rx_snap)));
    // R9: a held transmit stamp stays until its high word is read.
    p_hold_tx_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_stamp_valid && !(reg_rd && reg_addr == A_TXHI)) |=> (tx_stamp_valid && $stable(tx_snap)));
    // R9: a high-word read frees the receive stamp.
    p_clear_rx_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rd && reg_addr == A_RXHI) |=> !rx_stamp_valid);
    // R9: a high-word read frees the transmit stamp.
    p_clear_tx_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rd && reg_addr == A_TXHI) |=> !tx_stamp_valid);
    // R8: the receive flag rises two edges after a receive last byte.
    p_rise_rx_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rx_stamp_valid) |-> $past(rx_vld && rx_last, 2));
    // R10: the transmit flag rises two edges after a transmit last byte.
    p_rise_tx_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tx_stamp_valid) |-> $past(tx_vld && tx_last, 2));
endmodule

bind ptp_event_classifier ptp_event_classifier_chk #(.TS_W(TS_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .rx_vld(rx_vld), .rx_last(rx_last),
    .tx_vld(tx_vld), .tx_last(tx_last), .reg_rd(reg_rd), .reg_addr(reg_addr),
    .rx_stamp_valid(rx_stamp_valid), .tx_stamp_valid(tx_stamp_valid),
    .rx_snap(snap_w[0]), .tx_snap(snap_w[1])
);

// File: tb/ptp_event_classifier_tb_top.sv
// Self-checking bench: sweeps message-type bytes and type masks, and walks
// each field, the short-frame cutoff, the hold rule and the transmit gate.
module ptp_event_classifier_tb_top;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        rx_sof = 0, rx_vld = 0, rx_last = 0;
    logic [7:0]  rx_data = 0;
    logic        tx_sof = 0, tx_vld = 0, tx_last = 0;
    logic [7:0]  tx_data = 0;
    logic [15:0] tx_len_word = 0;
    logic [63:0] tnow = 64'hFF80_0000_0000_0000;
    logic        reg_wr = 0, reg_rd = 0;
    logic [3:0]  reg_addr = 0;
    logic [31:0] reg_wdata = 0;
    logic [31:0] reg_rdata;
    logic        rx_stamp_valid, tx_stamp_valid;

    int          checks = 0;
    int          failures = 0;
    logic [7:0]  fb [0:127];
    logic [63:0] sof_time;
    logic [31:0] rv;

    ptp_event_classifier dut_i (
        .clk(clk), .rst_n(rst_n),
        .rx_sof(rx_sof), .rx_vld(rx_vld), .rx_last(rx_last), .rx_data(rx_data),
        .tx_sof(tx_sof), .tx_vld(tx_vld), .tx_last(tx_last), .tx_data(tx_data),
        .tx_len_word(tx_len_word), .time_now(tnow),
        .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .rx_stamp_valid(rx_stamp_valid), .tx_stamp_valid(tx_stamp_valid)
    );

    always #(CLK_PERIOD/2) clk = ~clk;
    always @(posedge clk) tnow <= tnow + 64'd40;

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk); reg_wr = 1; reg_addr = a; reg_wdata = d;
        @(negedge clk); reg_wr = 0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [31:0] d);
        @(negedge clk); reg_rd = 1; reg_addr = a;
        #(CLK_PERIOD/4); d = reg_rdata;
        @(negedge clk); reg_rd = 0;
    endtask

    task automatic clear_frame();
        for (int i = 0; i < 128; i++) fb[i] = 8'h00;
    endtask

    task automatic build_udp(input logic [7:0] mt, input int ctl_at, input logic [15:0] et,
                             input logic [7:0] ver, input logic [7:0] proto, input logic [15:0] port);
        clear_frame();
        fb[12] = et[15:8]; fb[13] = et[7:0]; fb[14] = ver; fb[23] = proto;
        fb[36] = port[15:8]; fb[37] = port[7:0]; fb[ctl_at] = mt;
    endtask

    task automatic build_l2(input logic [7:0] mt, input logic [15:0] et);
        clear_frame();
        fb[12] = et[15:8]; fb[13] = et[7:0]; fb[14] = mt;
    endtask

    task automatic send(input bit is_tx, input int n, input logic [15:0] lw);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if (is_tx) begin
                tx_vld = 1; tx_sof = (i == 0); tx_last = (i == n-1); tx_data = fb[i];
                if (i == 0) tx_len_word = lw;
            end else begin
                rx_vld = 1; rx_sof = (i == 0); rx_last = (i == n-1); rx_data = fb[i];
            end
            if (i == 0) sof_time = tnow;
        end
        @(negedge clk);
        rx_vld = 0; rx_sof = 0; rx_last = 0; tx_vld = 0; tx_sof = 0; tx_last = 0;
        repeat (3) @(negedge clk);
    endtask

    // Checks the flag of one direction; frees it and checks the stamp if held.
    task automatic expect_stamp(input bit is_tx, input bit exp, input string req);
        logic [31:0] st, lo, hi;
        rd(4'd5, st);
        chk(req, st[is_tx], exp);
        if (st[is_tx]) begin
            rd(is_tx ? 4'd8 : 4'd6, lo);
            rd(is_tx ? 4'd9 : 4'd7, hi);
            if (exp) chk({req, " R8 time"}, {hi, lo}, sof_time);
        end
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        failures++;
        $display("FAIL watchdog actual=running expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1;
        @(negedge clk);

        // R1 reset state
        rd(4'd0, rv); chk("R1 ctrl", rv, 32'h00001F00);
        rd(4'd1, rv); chk("R1 offs", rv, 32'h4A24170C);
        rd(4'd2, rv); chk("R1 valA", rv, 32'h11040800);
        rd(4'd3, rv); chk("R1 valB", rv, 32'h0140013F);
        rd(4'd4, rv); chk("R1 tmask", rv, 32'hFFFFFFFC);
        rd(4'd5, rv); chk("R1 status", rv, 32'h0);
        chk("R1 pins", {rx_stamp_valid, tx_stamp_valid}, 2'b00);

        // R6 version-1 UDP layout, all comparisons enabled, type sweep
        wr(4'd0, 32'h00000001);
        rd(4'd0, rv); chk("R2 ctrl readback", rv, 32'h00000001);
        for (int mt = 0; mt < 40; mt++) begin
            build_udp(8'(mt), 74, 16'h0800, 8'h45, 8'h11, 16'h013F);
            send(0, 90, 16'h0);
            expect_stamp(0, mt < 2, $sformatf("R6 v1 type %0d", mt));
        end

        // R6 version-2 UDP layout
        wr(4'd1, 32'h2A24170C); wr(4'd4, 32'hFFFFFFF0);
        rd(4'd1, rv); chk("R2 offs readback", rv, 32'h2A24170C);
        for (int mt = 0; mt < 8; mt++) begin
            build_udp(8'(mt), 42, 16'h0800, 8'h45, 8'h11, 16'h0140);
            send(0, 90, 16'h0);
            expect_stamp(0, mt < 4, $sformatf("R6 v2 type %0d", mt));
        end

        // Field-by-field checks in the version-1 layout
        wr(4'd1, 32'h4A24170C); wr(4'd4, 32'hFFFFFFFC);
        build_udp(8'd0, 74, 16'h86DD, 8'h45, 8'h11, 16'h013F); send(0, 90, 0);
        expect_stamp(0, 0, "R3 ethertype mismatch");
        build_udp(8'd0, 74, 16'h0800, 8'h65, 8'h11, 16'h013F); send(0, 90, 0);
        expect_stamp(0, 0, "R4 version mismatch");
        wr(4'd0, 32'h00000201);
        send(0, 90, 0);
        expect_stamp(0, 1, "R4 version masked");
        wr(4'd0, 32'h00000001);
        build_udp(8'd0, 74, 16'h0800, 8'h45, 8'h06, 16'h013F); send(0, 90, 0);
        expect_stamp(0, 0, "R4 protocol mismatch");
        build_udp(8'd1, 74, 16'h0800, 8'h45, 8'h11, 16'h0140); send(0, 90, 0);
        expect_stamp(0, 1, "R5 second port");
        build_udp(8'd1, 74, 16'h0800, 8'h45, 8'h11, 16'h0141); send(0, 90, 0);
        expect_stamp(0, 0, "R5 port mismatch");
        build_udp(8'd0, 74, 16'h0800, 8'h45, 8'h11, 16'h013F);
        send(0, 74, 0);
        expect_stamp(0, 0, "R7 frame ends before type byte");
        send(0, 75, 0);
        expect_stamp(0, 1, "R7 frame just reaches type byte");

        // Layer-2 layout: only EtherType and type comparisons
        wr(4'd0, 32'h00000E01); wr(4'd1, 32'h0E24170C);
        wr(4'd2, 32'h110488F7); wr(4'd4, 32'hFFFFFFF0);
        rd(4'd0, rv); chk("R2 ctrl mask readback", rv, 32'h00000E01);
        for (int mt = 0; mt < 40; mt++) begin
            build_l2(8'(mt), 16'h88F7); send(0, 64, 0);
            expect_stamp(0, mt < 4, $sformatf("R6 l2 type %0d", mt));
        end
        wr(4'd4, 32'h3C96A50F);
        for (int mt = 0; mt < 40; mt++) begin
            logic [31:0] m;
            m = 32'h3C96A50F;
            build_l2(8'(mt), 16'h88F7); send(0, 64, 0);
            expect_stamp(0, (mt < 32) && !m[mt % 32], $sformatf("R6 l2 pattern type %0d", mt));
        end
        wr(4'd4, 32'hFFFFFFFF);
        for (int mt = 0; mt < 8; mt++) begin
            build_l2(8'(mt), 16'h88F7); send(0, 64, 0);
            expect_stamp(0, 0, $sformatf("R12 all blocked type %0d", mt));
        end
        wr(4'd4, 32'hFFFFFFF0);
        build_l2(8'd0, 16'h0800); send(0, 64, 0);
        expect_stamp(0, 0, "R3 l2 wrong ethertype");

        // R9 hold and clear
        begin
            logic [63:0] first;
            build_l2(8'd0, 16'h88F7); send(0, 64, 0);
            first = sof_time;
            build_l2(8'd1, 16'h88F7); send(0, 64, 0);
            rd(4'd5, rv); chk("R9 flag after two events", rv[0], 1'b1);
            rd(4'd6, rv); chk("R9 low word keeps first", rv, first[31:0]);
            rd(4'd5, rv); chk("R9 low read keeps flag", rv[0], 1'b1);
            rd(4'd7, rv); chk("R9 high word keeps first", rv, first[63:32]);
            rd(4'd5, rv); chk("R9 high read clears", rv[0], 1'b0);
            send(0, 64, 0);
            expect_stamp(0, 1, "R9 capture after clear");
        end

        // R10 transmit gating
        build_l2(8'd0, 16'h88F7);
        send(1, 64, 16'h0040); expect_stamp(1, 0, "R10 request bit clear");
        send(1, 64, 16'hEFFF); expect_stamp(1, 0, "R10 other bits set");
        send(1, 64, 16'h1040); expect_stamp(1, 1, "R10 request bit set");
        send(0, 64, 16'h0);
        rd(4'd5, rv); chk("R10 rx event leaves tx flag", rv, 32'h1);
        rd(4'd7, rv);
        for (int mt = 0; mt < 6; mt++) begin
            build_l2(8'(mt), 16'h88F7); send(1, 64, 16'h1040);
            expect_stamp(1, mt < 4, $sformatf("R10 tx type %0d", mt));
        end

        // R11 global enable off
        wr(4'd0, 32'h00000E00);
        build_l2(8'd0, 16'h88F7);
        send(0, 64, 0); expect_stamp(0, 0, "R11 disabled rx");
        send(1, 64, 16'h1040); expect_stamp(1, 0, "R11 disabled tx");

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule